// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block is a synthesizable behavioural model of the erase side of a parallel flash command interface. It watches write strobes on an active-low write enable. Each strobe carries an address and a data byte. The block recognises a protected six-write command sequence: five fixed unlock writes, then a sixth write whose data byte chooses the erase size. That size is one 4 KiB sector, one block, or the whole array. After a complete sequence it starts a timed internal erase and holds `busy` high for a fixed number of clock cycles. When the erase finishes, the selected region of its internal array reads as all ones.

Only erase can change the array, and reset returns every location to 00h. The contents are therefore always uniform within a 4 KiB sector, so the array keeps one state bit per sector. A status block or test harness observes the array through a sector-indexed read port. Write enable is sampled against the system clock, and a write is taken on the clock edge where a low-to-high transition of `we_n` is first seen.

Top module: `flash_erase_seq`

## Requirements
- R1: A write is taken at the clock edge where `we_n` is sampled high after having been sampled low at the previous edge. `addr` and `din` are sampled at that edge. The five unlock writes, in order, are addr[14:0]/din = 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh and 2AAAh/55h. Address bits above bit 14 are not compared.
- R2: A write during the unlock phase that does not match the expected unlock write returns the decoder to its first step. That write is consumed and does not count as the first unlock write of a new sequence.
- R3: A sixth write with din = 30h erases only the 4 KiB sector numbered addr[ADDR_W-1:12].
- R4: A sixth write with din = 50h erases the block that contains sector addr[ADDR_W-1:12]. A block is 16 sectors (64 KiB) when SMALL_BLOCK = 0 and 4 sectors (16 KiB) when SMALL_BLOCK = 1.
- R5: A sixth write with din = 10h, addr[14:0] = 5555h and `pp_mode` = 1 erases every sector. If `pp_mode` = 0 or the address differs, nothing is erased, `busy` stays low and the decoder returns to its first step.
- R6: A sixth write with any other data value starts no erase and returns the decoder to its first step.
- R7: `busy` rises at the clock edge that takes the sixth write and stays high for exactly ERASE_CYC clock cycles.
- R8: After reset every sector reads 00h. The erased region reads FFh from the edge where `busy` falls, and not before. Sectors outside the region are unchanged.
- R9: Every write taken while `busy` is high is ignored. It neither advances the unlock sequence nor starts or changes an erase.
- R10: `rd_data` is FFh when sector `rd_sector` has been erased since reset, and 00h otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| we_n | input | 1 | Active-low write enable, synchronous to clk |
| addr | input | ADDR_W | Byte address of the write |
| din | input | 8 | Data byte of the write |
| pp_mode | input | 1 | High when parallel-programming mode is selected (enables chip erase) |
| rd_sector | input | ADDR_W-12 | Sector index to observe |
| rd_data | output | 8 | Uniform content byte of the observed sector |
| busy | output | 1 | High while an internal erase is running |

## Verification
The assertions assume that `we_n`, `addr`, `din` and `pp_mode` are already synchronous to `clk`. They also assume that `addr` and `din` are stable at the edge where the write-enable rise is taken, and that reset is held for at least two edges while no erase is running. The bench meets these assumptions in several ways. It changes every input only on the falling clock edge and holds write enable low for one full cycle per write. It keeps address and data unchanged until after the rising edge of write enable is taken. It asserts reset for three cycles between cases, and only after `busy` has dropped.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [1:0] {
    ER_NONE   = 2'd0,
    ER_SECTOR = 2'd1,
    ER_BLOCK  = 2'd2,
    ER_CHIP   = 2'd3
  } erase_kind_t;

  localparam int UNLOCK_STEPS = 5;

  function automatic logic [14:0] unlock_addr(input logic [2:0] step);
    case (step)
      3'd1, 3'd4: return 15'h2AAA;
      default:    return 15'h5555;
    endcase
  endfunction

  function automatic logic [7:0] unlock_data(input logic [2:0] step);
    case (step)
      3'd1, 3'd4: return 8'h55;
      3'd2:       return 8'h80;
      default:    return 8'hAA;
    endcase
  endfunction

  function automatic erase_kind_t decode_op(input logic [7:0] d,
                                            input logic [14:0] a15,
                                            input logic pp);
    if (d == 8'h30) return ER_SECTOR;
    if (d == 8'h50) return ER_BLOCK;
    if (d == 8'h10 && a15 == 15'h5555 && pp) return ER_CHIP;
    return ER_NONE;
  endfunction

  function automatic logic region_hit(input erase_kind_t k,
                                      input int unsigned idx,
                                      input int unsigned tgt,
                                      input int unsigned blk_shift);
    case (k)
      ER_SECTOR: return idx == tgt;
      ER_BLOCK:  return (idx >> blk_shift) == (tgt >> blk_shift);
      ER_CHIP:   return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fes_wr_edge.sv
module fes_wr_edge (
  input  logic clk,
  input  logic rst,
  input  logic we_n,
  output logic wr_stb
);
  logic we_d;

  always_ff @(posedge clk) begin
    if (rst) we_d <= 1'b1;
    else     we_d <= we_n;
  end

  assign wr_stb = we_n & ~we_d;

  assert_stb_edge_R1: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/fes_cmd_seq.sv
module fes_cmd_seq
  import flash_erase_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_stb,
  input  logic        hold,
  input  logic [14:0] a15,
  input  logic [7:0]  din,
  input  logic        pp_mode,
  output logic        fire,
  output erase_kind_t kind
);
  logic [2:0] step;
  logic       take;
  logic       unlock_ok;
  logic       last_step;

  assign take      = wr_stb & ~hold;
  assign last_step = (step == 3'(UNLOCK_STEPS));
  assign unlock_ok = (a15 == unlock_addr(step)) && (din == unlock_data(step));
  assign kind      = decode_op(din, a15, pp_mode);
  assign fire      = take && last_step && (kind != ER_NONE);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      step <= 3'd0;
    end else if (take) begin
      if (!last_step && unlock_ok) step <= step + 3'd1;
      else                         step <= 3'd0;
    end
  end

  assert_mismatch_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (take && !last_step && !unlock_ok) |=> (step == 3'd0));
  assert_sixth_resets_R6: assert property (@(posedge clk) disable iff (rst)
    (take && last_step) |=> (step == 3'd0));
  assert_step_range_R1: assert property (@(posedge clk) disable iff (rst)
    step <= 3'(UNLOCK_STEPS));
endmodule

// File: rtl/fes_erase_eng.sv
module fes_erase_eng
  import flash_erase_pkg::*;
#(
  parameter int SECT_W    = 6,
  parameter int BLK_SHIFT = 4,
  parameter int ERASE_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  erase_kind_t       kind_in,
  input  logic [SECT_W-1:0] tgt_in,
  input  logic [SECT_W-1:0] rd_sect,
  output logic              rd_bit,
  output logic              busy
);
  localparam int NSECT = 1 << SECT_W;
  localparam int CNT_W = $clog2(ERASE_CYC + 1);

  logic [NSECT-1:0]  mem;
  logic [NSECT-1:0]  hit_vec;
  logic [CNT_W-1:0]  cnt;
  erase_kind_t       kind_q;
  logic [SECT_W-1:0] tgt_q;
  logic              done;

  assign done = busy && (cnt == '0);

  for (genvar i = 0; i < NSECT; i++) begin : g_hit
    assign hit_vec[i] = region_hit(kind_q, 32'(i), 32'(tgt_q), BLK_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      kind_q <= ER_NONE;
      tgt_q  <= '0;
      mem    <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        cnt    <= CNT_W'(ERASE_CYC - 1);
        kind_q <= kind_in;
        tgt_q  <= tgt_in;
      end
    end else if (done) begin
      busy <= 1'b0;
      mem  <= mem | hit_vec;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign rd_bit = mem[rd_sect];

  // Independent length counter for the busy window checks
  logic [CNT_W:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  assert_busy_max_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_len < (CNT_W+1)'(ERASE_CYC)));
  assert_busy_len_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == (CNT_W+1)'(ERASE_CYC)));
  assert_only_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (($past(mem) & ~mem) == '0));
  assert_stable_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(mem));
  assert_stable_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(mem));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int SMALL_BLOCK = 0,
  parameter int ERASE_CYC   = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              pp_mode,
  input  logic [ADDR_W-13:0] rd_sector,
  output logic [7:0]        rd_data,
  output logic              busy
);
  localparam int SECT_W    = ADDR_W - 12;
  localparam int BLK_SHIFT = (SMALL_BLOCK != 0) ? 2 : 4;

  logic        wr_stb;
  logic        seq_fire;
  erase_kind_t seq_kind;
  logic        rd_bit;

  fes_wr_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .we_n  (we_n),
    .wr_stb(wr_stb)
  );

  fes_cmd_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (wr_stb),
    .hold   (busy),
    .a15    (addr[14:0]),
    .din    (din),
    .pp_mode(pp_mode),
    .fire   (seq_fire),
    .kind   (seq_kind)
  );

  fes_erase_eng #(
    .SECT_W   (SECT_W),
    .BLK_SHIFT(BLK_SHIFT),
    .ERASE_CYC(ERASE_CYC)
  ) u_eng (
    .clk    (clk),
    .rst    (rst),
    .start  (seq_fire),
    .kind_in(seq_kind),
    .tgt_in (addr[ADDR_W-1:12]),
    .rd_sect(rd_sector),
    .rd_bit (rd_bit),
    .busy   (busy)
  );

  assign rd_data = {8{rd_bit}};

  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !seq_fire);
  assert_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(seq_fire));
  assert_chip_mode_R5: assert property (@(posedge clk) disable iff (rst)
    (seq_fire && seq_kind == ER_CHIP) |-> pp_mode);
  assert_fire_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    seq_fire |-> wr_stb);
endmodule

// File: tb/flash_erase_seq_test.sv
`timescale 1ns/1ps
module flash_erase_seq_test;
  localparam int AW = 17;
  localparam int NS = 1 << (AW - 12);
  localparam int EC = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          pp_mode = 1'b1;
  logic [AW-13:0] rd_sector = '0;
  logic [7:0]    rd_data, rd_data_sb;
  logic          busy, busy_sb;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  flash_erase_seq #(.ADDR_W(AW), .SMALL_BLOCK(0), .ERASE_CYC(EC)) uut (
    .clk(clk), .rst(rst), .we_n(we_n), .addr(addr), .din(din),
    .pp_mode(pp_mode), .rd_sector(rd_sector), .rd_data(rd_data), .busy(busy));

  flash_erase_seq #(.ADDR_W(AW), .SMALL_BLOCK(1), .ERASE_CYC(EC)) uut_sb (
    .clk(clk), .rst(rst), .we_n(we_n), .addr(addr), .din(din),
    .pp_mode(pp_mode), .rd_sector(rd_sector), .rd_data(rd_data_sb), .busy(busy_sb));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: act timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    we_n = 1'b0; addr = a; din = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock5();
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55);
  endtask

  // kind: 0 none, 1 sector, 2 block, 3 chip; shift = log2 sectors per block
  function automatic logic exp_hit(input int k, input int i, input int s, input int sh);
    if (k == 1) return i == s;
    if (k == 2) return (i / (1 << sh)) == (s / (1 << sh));
    if (k == 3) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check_all(input string req, input int k, input int s);
    for (int i = 0; i < NS; i++) begin
      rd_sector = (AW-12)'(i);
      #0.5;
      chk(req, int'(rd_data), exp_hit(k, i, s, 4) ? 8'hFF : 8'h00);
      chk({req, "_sb"}, int'(rd_data_sb), exp_hit(k, i, s, 2) ? 8'hFF : 8'h00);
    end
  endtask

  // called right after the sixth write returned
  task automatic expect_erase(input int s);
    int n = 0;
    chk("R7 busy rises", int'(busy), 1);
    rd_sector = (AW-12)'(s);
    #0.5;
    chk("R8 not before end", int'(rd_data), 0);
    while (busy && n < 200) begin
      n++;
      chk("R7 busy equal", int'(busy_sb), int'(busy));
      @(negedge clk);
    end
    chk("R7 busy length", n, EC);
  endtask

  task automatic expect_none();
    for (int j = 0; j < 4; j++) begin
      chk("R6 no busy", int'(busy), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    do_reset();
    chk("R8 reset busy", int'(busy), 0);
    check_all("R8 reset", 0, 0);

    // R3 sector erase sweep, in-sector offset bits nonzero
    for (int s = 0; s < NS; s++) begin
      do_reset();
      unlock5();
      wr(AW'((s << 12) | 12'hA5C), 8'h30);
      expect_erase(s);
      check_all("R3 sector", 1, s);
    end

    // R4 block erase sweep
    for (int s = 0; s < NS; s += 3) begin
      do_reset();
      unlock5();
      wr(AW'((s << 12) | 12'h123), 8'h50);
      expect_erase(s);
      check_all("R4 block", 2, s);
    end

    // R5 chip erase
    do_reset();
    unlock5();
    wr(17'h05555, 8'h10);
    expect_erase(0);
    check_all("R5 chip", 3, 0);

    // R5 chip refused without mode
    do_reset();
    pp_mode = 1'b0;
    unlock5();
    wr(17'h05555, 8'h10);
    expect_none();
    check_all("R5 no mode", 0, 0);
    pp_mode = 1'b1;
    // decoder back at step one: sector erase works directly
    unlock5();
    wr(17'h03000, 8'h30);
    expect_erase(3);
    check_all("R5 idle after refuse", 1, 3);

    // R5 chip wrong address
    do_reset();
    unlock5();
    wr(17'h05556, 8'h10);
    expect_none();
    check_all("R5 bad addr", 0, 0);

    // R6 unknown opcodes
    do_reset();
    unlock5(); wr(17'h05555, 8'h20); expect_none();
    unlock5(); wr(17'h05555, 8'hA0); expect_none();
    check_all("R6 unknown op", 0, 0);

    // R1 upper address bits ignored in unlock
    do_reset();
    wr(17'h15555, 8'hAA); wr(17'h1AAAA, 8'h55); wr(17'h15555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h12AAA, 8'h55);
    wr(17'h07000, 8'h30);
    expect_erase(7);
    check_all("R1 upper bits", 1, 7);

    // R2 mismatch at third cycle then rest of sequence
    do_reset();
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h90);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55);
    wr(17'h05000, 8'h30);
    expect_none();
    check_all("R2 mismatch", 0, 0);

    // R2 mismatched write not reused as first unlock write
    do_reset();
    wr(17'h05555, 8'hAA); wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80); wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55); wr(17'h02000, 8'h30);
    expect_none();
    check_all("R2 consumed", 0, 0);

    // R9 unlock during busy does not carry over
    do_reset();
    unlock5();
    wr(17'h03000, 8'h30);
    chk("R9 busy", int'(busy), 1);
    unlock5();
    while (busy) @(negedge clk);
    wr(17'h07000, 8'h30);
    expect_none();
    check_all("R9 unlock ignored", 1, 3);

    // R9 full sequence during busy ignored
    do_reset();
    unlock5();
    wr(17'h04000, 8'h30);
    unlock5();
    wr(17'h09000, 8'h30);
    chk("R9 still first erase", int'(busy), 1);
    while (busy) @(negedge clk);
    expect_none();
    check_all("R9 seq ignored", 1, 4);

    // R10 accumulation of two erases without reset
    do_reset();
    unlock5(); wr(17'h01000, 8'h30); expect_erase(1);
    unlock5(); wr(17'h1F000, 8'h30); expect_erase(31);
    for (int i = 0; i < NS; i++) begin
      rd_sector = (AW-12)'(i);
      #0.5;
      chk("R10 read", int'(rd_data), (i == 1 || i == 31) ? 8'hFF : 8'h00);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule